// File: doc/BRIEF.md
# Trap Return Status Update Unit

This unit carries out the two trap-return operations of a RISC-V style core: the supervisor-level return and the machine-level return. When the pipeline issues a one-cycle request, the unit reads the current privilege level, the virtualization flag, the machine and hypervisor status words, the two exception PCs, a flag that says whether compressed instructions are supported, and a flag that says whether any memory-protection rule is configured. It first decides whether the return is legal. It then either reports a trap with a cause code, or commits the whole status update, the new privilege, the new virtualization flag and the return address together in one registered step.

Legality is settled by a fixed list of checks, and the first failing check in the list wins. If a trap is reported, every piece of architectural state passes through unchanged. The unit does not swap hypervisor register banks and does not redirect the fetch stream. Those jobs belong to the surrounding core, which uses `done_o`, `exc_o`, `cause_o` and `ret_pc_o`. A build parameter, `HYP_EN`, selects whether the hypervisor-aware parts are present.

Top module: `trapret_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first request, `done_o` and `exc_o` are 0, and `cause_o`, `mstatus_o`, `hstatus_o`, `priv_o`, `virt_o` and `ret_pc_o` are all zero.
- R2: `done_o` is 1 in exactly the cycle after each cycle in which `req_i` is 1, and is 0 otherwise. `exc_o` can be 1 only in such a cycle. While no request is made, all state outputs and `ret_pc_o` hold their last values, whatever the inputs do.
- R3: Privilege is encoded as user 2'b00, supervisor 2'b01 and machine 2'b11. A supervisor return (`is_mret_i`=0) requested at user privilege traps with `cause_o`=2, the illegal-instruction code.
- R4: A return traps as misaligned (`cause_o`=0) when `rvc_i`=0 and bits [1:0] of the selected return PC are not zero. This check ranks directly below the privilege check of R3 or R9.
- R5: A supervisor return traps with `cause_o`=2 when `mstatus_i` bit 22 (trap-on-sret) is set and the privilege is not machine. This check ranks below alignment.
- R6: When `HYP_EN`=1, a supervisor return traps with `cause_o`=22 (virtual-instruction fault) when `virt_i`=1 and `hstatus_i` bit 22 (virtual trap-on-sret) is set. This check ranks last. When `HYP_EN`=0, it never fires.
- R7: A legal supervisor return copies `mstatus` bit 5 (previous supervisor enable) into bit 1 (supervisor enable), sets bit 5, clears bit 8 (previous supervisor mode), and sets `priv_o` to {1'b0, old bit 8}. All other `mstatus` bits are unchanged.
- R8: When `HYP_EN`=1 and `virt_i`=0, a legal supervisor return sets `virt_o` to `hstatus_i` bit 7 (previous virtualization) and clears that bit. In every other case, `virt_o` equals `virt_i` and `hstatus_o` equals `hstatus_i`.
- R9: A machine return (`is_mret_i`=1) traps with `cause_o`=2 when the privilege is not machine. It also traps with `cause_o`=2, ranked below alignment, when `pmp_any_i`=0 and `mstatus` bits [12:11] (previous machine mode) are not 2'b11.
- R10: A legal machine return copies `mstatus` bit 7 into bit 3, sets bit 7, clears bits [12:11] and bit 39 (previous machine virtualization), and sets `priv_o` to the old bits [12:11]. `virt_o` becomes the old bit 39 when `HYP_EN`=1 and stays `virt_i` otherwise. `hstatus_o` equals `hstatus_i`. All other `mstatus` bits are unchanged.
- R11: On a trapped request, `mstatus_o`, `hstatus_o`, `priv_o` and `virt_o` equal the inputs of the request cycle. On every request, `ret_pc_o` is `mepc_i` for a machine return and `sepc_i` for a supervisor return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle trap-return request |
| is_mret_i | input | 1 | 1 = machine return, 0 = supervisor return |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Current virtualization flag |
| mstatus_i | input | 64 | Current machine status word |
| hstatus_i | input | 64 | Current hypervisor status word |
| sepc_i | input | XLEN | Supervisor exception PC |
| mepc_i | input | XLEN | Machine exception PC |
| rvc_i | input | 1 | Compressed instructions supported |
| pmp_any_i | input | 1 | At least one memory-protection rule configured |
| done_o | output | 1 | Request completed (one cycle after `req_i`) |
| exc_o | output | 1 | Request trapped |
| cause_o | output | 5 | Trap cause of the last request |
| mstatus_o | output | 64 | Updated machine status word |
| hstatus_o | output | 64 | Updated hypervisor status word |
| priv_o | output | 2 | New privilege level |
| virt_o | output | 1 | New virtualization flag |
| ret_pc_o | output | XLEN | Return address |

## Verification
The bench builds two copies with `XLEN`=32: one with `HYP_EN`=1 and one with `HYP_EN`=0. Both are driven with the same stimulus, so the hypervisor-only paths can be compared directly against their absence. The sweep covers every combination of:
- return kind;
- all four privilege codes, including the reserved one;
- the virtualization flag;
- compressed support;
- all four low PC bit patterns;
- the trap-on-sret and virtual trap-on-sret bits;
- the protection flag;
- all four previous machine modes;
- the previous supervisor mode, the stacked enables and the previous virtualization bits.

This reaches every ordering conflict between the legality checks. The remaining status bits are filled with random values, so any write to a bit that should be left alone shows up in the comparison.

// File: rtl/trapret_pkg.sv
package trapret_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;

  localparam int ST_W = 64;

  // machine status bit positions
  localparam int MS_SIE    = 1;
  localparam int MS_MIE    = 3;
  localparam int MS_SPIE   = 5;
  localparam int MS_MPIE   = 7;
  localparam int MS_SPP    = 8;
  localparam int MS_MPP_LO = 11;
  localparam int MS_MPP_HI = 12;
  localparam int MS_TSR    = 22;
  localparam int MS_MPV    = 39;

  // hypervisor status bit positions
  localparam int HS_SPV  = 7;
  localparam int HS_VTSR = 22;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

  // number of ordered legality checks
  localparam int N_CHECKS = 4;

  typedef struct packed {
    logic [ST_W-1:0] ms;
    logic [ST_W-1:0] hs;
    logic [1:0]      priv;
    logic            virt;
  } arch_state_t;

  function automatic logic pc_misaligned(input logic [1:0] pc_lo, input logic rvc);
    return (!rvc) && (pc_lo != 2'b00);
  endfunction

  // pop the supervisor enable stack
  function automatic logic [ST_W-1:0] sret_pop(input logic [ST_W-1:0] ms);
    logic [ST_W-1:0] r;
    r          = ms;
    r[MS_SIE]  = ms[MS_SPIE];
    r[MS_SPIE] = 1'b1;
    r[MS_SPP]  = 1'b0;
    return r;
  endfunction

  // pop the machine enable stack
  function automatic logic [ST_W-1:0] mret_pop(input logic [ST_W-1:0] ms);
    logic [ST_W-1:0] r;
    r                      = ms;
    r[MS_MIE]              = ms[MS_MPIE];
    r[MS_MPIE]             = 1'b1;
    r[MS_MPP_HI:MS_MPP_LO] = 2'b00;
    r[MS_MPV]              = 1'b0;
    return r;
  endfunction

  function automatic logic [1:0] sret_target(input logic [ST_W-1:0] ms);
    return {1'b0, ms[MS_SPP]};
  endfunction

  function automatic logic [1:0] mret_target(input logic [ST_W-1:0] ms);
    return ms[MS_MPP_HI:MS_MPP_LO];
  endfunction

endpackage

// File: rtl/trapret_legality.sv
module trapret_legality
  import trapret_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input  logic               is_mret_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               tsr_i,
  input  logic               vtsr_i,
  input  logic [1:0]         mpp_i,
  input  logic [1:0]         pc_lo_i,
  input  logic               rvc_i,
  input  logic               pmp_any_i,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o
);

  priv_e cur_priv;
  assign cur_priv = priv_e'(priv_i);

  // ordered check outcomes, index 0 has highest precedence
  logic [N_CHECKS-1:0] sret_hit;
  logic [N_CHECKS-1:0] mret_hit;
  logic [N_CHECKS-1:0] hit;
  logic [CAUSE_W-1:0]  code [N_CHECKS];

  logic misaligned;
  assign misaligned = pc_misaligned(pc_lo_i, rvc_i);

  assign sret_hit[0] = (cur_priv == PRIV_U);
  assign sret_hit[1] = misaligned;
  assign sret_hit[2] = tsr_i && (cur_priv != PRIV_M);

  generate
    if (HYP_EN) begin : g_vtsr
      assign sret_hit[3] = virt_i && vtsr_i;
    end else begin : g_no_vtsr
      logic unused_hyp;
      assign unused_hyp  = virt_i ^ vtsr_i;
      assign sret_hit[3] = 1'b0;
    end
  endgenerate

  assign mret_hit[0] = (cur_priv != PRIV_M);
  assign mret_hit[1] = misaligned;
  assign mret_hit[2] = (!pmp_any_i) && (priv_e'(mpp_i) != PRIV_M);
  assign mret_hit[3] = 1'b0;

  assign hit = is_mret_i ? mret_hit : sret_hit;

  assign code[0] = CAUSE_ILLEGAL;
  assign code[1] = CAUSE_MISALIGN;
  assign code[2] = CAUSE_ILLEGAL;
  assign code[3] = CAUSE_VIRT;

  // first failing check wins: scan from lowest to highest precedence
  always_comb begin
    fault_o = 1'b0;
    cause_o = '0;
    for (int i = N_CHECKS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        fault_o = 1'b1;
        cause_o = code[i];
      end
    end
  end

endmodule

// File: rtl/trapret_update.sv
module trapret_update
  import trapret_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input  logic        is_mret_i,
  input  arch_state_t cur_i,
  output arch_state_t nxt_o
);

  arch_state_t s_nxt;
  arch_state_t m_nxt;

  // status and privilege for a supervisor return
  always_comb begin
    s_nxt      = cur_i;
    s_nxt.ms   = sret_pop(cur_i.ms);
    s_nxt.priv = sret_target(cur_i.ms);
  end

  // status and privilege for a machine return
  always_comb begin
    m_nxt      = cur_i;
    m_nxt.ms   = mret_pop(cur_i.ms);
    m_nxt.priv = mret_target(cur_i.ms);
  end

  logic            s_virt;
  logic [ST_W-1:0] s_hs;
  logic            m_virt;

  generate
    if (HYP_EN) begin : g_hyp
      logic [ST_W-1:0] hs_cleared;
      always_comb begin
        hs_cleared         = cur_i.hs;
        hs_cleared[HS_SPV] = 1'b0;
      end
      // previous virtualization only consulted from host mode
      assign s_virt = cur_i.virt ? cur_i.virt : cur_i.hs[HS_SPV];
      assign s_hs   = cur_i.virt ? cur_i.hs   : hs_cleared;
      assign m_virt = cur_i.ms[MS_MPV];
    end else begin : g_nohyp
      assign s_virt = cur_i.virt;
      assign s_hs   = cur_i.hs;
      assign m_virt = cur_i.virt;
    end
  endgenerate

  always_comb begin
    if (is_mret_i) begin
      nxt_o      = m_nxt;
      nxt_o.virt = m_virt;
    end else begin
      nxt_o      = s_nxt;
      nxt_o.virt = s_virt;
      nxt_o.hs   = s_hs;
    end
  end

endmodule

// File: rtl/trapret_unit.sv
module trapret_unit
  import trapret_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter bit HYP_EN = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               is_mret_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic [ST_W-1:0]    mstatus_i,
  input  logic [ST_W-1:0]    hstatus_i,
  input  logic [XLEN-1:0]    sepc_i,
  input  logic [XLEN-1:0]    mepc_i,
  input  logic               rvc_i,
  input  logic               pmp_any_i,
  output logic               done_o,
  output logic               exc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [ST_W-1:0]    mstatus_o,
  output logic [ST_W-1:0]    hstatus_o,
  output logic [1:0]         priv_o,
  output logic               virt_o,
  output logic [XLEN-1:0]    ret_pc_o
);

  arch_state_t        cur_w;
  arch_state_t        nxt_w;
  arch_state_t        state_q;
  logic [XLEN-1:0]    target_pc_w;
  logic               fault_w;
  logic [CAUSE_W-1:0] fault_cause_w;
  logic               commit_w;
  logic               trap_w;

  assign cur_w.ms   = mstatus_i;
  assign cur_w.hs   = hstatus_i;
  assign cur_w.priv = priv_i;
  assign cur_w.virt = virt_i;

  assign target_pc_w = is_mret_i ? mepc_i : sepc_i;

  trapret_legality #(
    .HYP_EN(HYP_EN)
  ) u_legal (
    .is_mret_i (is_mret_i),
    .priv_i    (priv_i),
    .virt_i    (virt_i),
    .tsr_i     (mstatus_i[MS_TSR]),
    .vtsr_i    (hstatus_i[HS_VTSR]),
    .mpp_i     (mstatus_i[MS_MPP_HI:MS_MPP_LO]),
    .pc_lo_i   (target_pc_w[1:0]),
    .rvc_i     (rvc_i),
    .pmp_any_i (pmp_any_i),
    .fault_o   (fault_w),
    .cause_o   (fault_cause_w)
  );

  trapret_update #(
    .HYP_EN(HYP_EN)
  ) u_update (
    .is_mret_i (is_mret_i),
    .cur_i     (cur_w),
    .nxt_o     (nxt_w)
  );

  // named events for the checker
  assign commit_w = req_i && !fault_w;
  assign trap_w   = req_i &&  fault_w;

  logic               done_q;
  logic               exc_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [XLEN-1:0]    pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      exc_q   <= 1'b0;
      cause_q <= '0;
      state_q <= '0;
      pc_q    <= '0;
    end else begin
      done_q <= req_i;
      exc_q  <= trap_w;
      if (req_i) begin
        cause_q <= fault_w ? fault_cause_w : '0;
        pc_q    <= target_pc_w;
      end
      if (commit_w) begin
        state_q <= nxt_w;
      end else if (trap_w) begin
        state_q <= cur_w;
      end
    end
  end

  assign done_o    = done_q;
  assign exc_o     = exc_q;
  assign cause_o   = cause_q;
  assign mstatus_o = state_q.ms;
  assign hstatus_o = state_q.hs;
  assign priv_o    = state_q.priv;
  assign virt_o    = state_q.virt;
  assign ret_pc_o  = pc_q;

endmodule

// File: rtl/trapret_unit_sva.sv
module trapret_unit_sva
  import trapret_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               is_mret_i,
  input logic [1:0]         priv_i,
  input logic               virt_i,
  input logic [ST_W-1:0]    mstatus_i,
  input logic [ST_W-1:0]    hstatus_i,
  input logic               done_o,
  input logic               exc_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [ST_W-1:0]    mstatus_o,
  input logic [ST_W-1:0]    hstatus_o,
  input logic [1:0]         priv_o,
  input logic               virt_o
);

  p_done_after_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);

  p_quiet_when_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!done_o && !exc_o));

  p_hold_when_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(mstatus_o) && $stable(hstatus_o) && $stable(priv_o) && $stable(virt_o)));

  p_user_sret_illegal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !is_mret_i && priv_i == 2'b00) |=> (exc_o && cause_o == CAUSE_ILLEGAL));

  p_cause_known_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (cause_o == CAUSE_MISALIGN || cause_o == CAUSE_ILLEGAL || cause_o == CAUSE_VIRT));

  p_sret_pop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !is_mret_i) |=> (exc_o ||
      (mstatus_o[MS_SPIE] && !mstatus_o[MS_SPP] &&
       mstatus_o[MS_SIE] == $past(mstatus_i[MS_SPIE]) &&
       priv_o == {1'b0, $past(mstatus_i[MS_SPP])})));

  p_nonm_mret_illegal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_mret_i && priv_i != 2'b11) |=> (exc_o && cause_o == CAUSE_ILLEGAL));

  p_mret_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && is_mret_i) |=> (exc_o ||
      (mstatus_o[MS_MPP_HI:MS_MPP_LO] == 2'b00 && mstatus_o[MS_MPIE] && !mstatus_o[MS_MPV] &&
       mstatus_o[MS_MIE] == $past(mstatus_i[MS_MPIE]) &&
       priv_o == $past(mstatus_i[MS_MPP_HI:MS_MPP_LO]) &&
       hstatus_o == $past(hstatus_i))));

  p_trap_freezes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!exc_o ||
      (mstatus_o == $past(mstatus_i) && hstatus_o == $past(hstatus_i) &&
       priv_o == $past(priv_i) && virt_o == $past(virt_i))));

endmodule

bind trapret_unit trapret_unit_sva u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .is_mret_i (is_mret_i),
  .priv_i    (priv_i),
  .virt_i    (virt_i),
  .mstatus_i (mstatus_i),
  .hstatus_i (hstatus_i),
  .done_o    (done_o),
  .exc_o     (exc_o),
  .cause_o   (cause_o),
  .mstatus_o (mstatus_o),
  .hstatus_o (hstatus_o),
  .priv_o    (priv_o),
  .virt_o    (virt_o)
);

// File: tb/tb_trapret_unit.sv
`timescale 1ns/1ps
module tb_trapret_unit;

  localparam int XW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req;
  logic          is_mret;
  logic [1:0]    priv;
  logic          virt;
  logic [63:0]   ms_in;
  logic [63:0]   hs_in;
  logic [XW-1:0] sepc;
  logic [XW-1:0] mepc;
  logic          rvc;
  logic          pmp_any;

  logic          done_a, exc_a, virt_a;
  logic [4:0]    cause_a;
  logic [63:0]   ms_a, hs_a;
  logic [1:0]    priv_a;
  logic [XW-1:0] pc_a;

  logic          done_b, exc_b, virt_b;
  logic [4:0]    cause_b;
  logic [63:0]   ms_b, hs_b;
  logic [1:0]    priv_b;
  logic [XW-1:0] pc_b;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  trapret_unit #(.XLEN(XW), .HYP_EN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .is_mret_i(is_mret), .priv_i(priv),
    .virt_i(virt), .mstatus_i(ms_in), .hstatus_i(hs_in), .sepc_i(sepc), .mepc_i(mepc),
    .rvc_i(rvc), .pmp_any_i(pmp_any), .done_o(done_a), .exc_o(exc_a), .cause_o(cause_a),
    .mstatus_o(ms_a), .hstatus_o(hs_a), .priv_o(priv_a), .virt_o(virt_a), .ret_pc_o(pc_a));

  trapret_unit #(.XLEN(XW), .HYP_EN(1'b0)) dut_nh (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .is_mret_i(is_mret), .priv_i(priv),
    .virt_i(virt), .mstatus_i(ms_in), .hstatus_i(hs_in), .sepc_i(sepc), .mepc_i(mepc),
    .rvc_i(rvc), .pmp_any_i(pmp_any), .done_o(done_b), .exc_o(exc_b), .cause_o(cause_b),
    .mstatus_o(ms_b), .hstatus_o(hs_b), .priv_o(priv_b), .virt_o(virt_b), .ret_pc_o(pc_b));

  task automatic chk(input bit ok, input string req_tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic model(input bit h, output bit e_exc, output logic [4:0] e_cause,
                       output logic [63:0] e_ms, output logic [63:0] e_hs,
                       output logic [1:0] e_priv, output logic e_virt, output string tag);
    logic [XW-1:0] pc;
    bit mis;
    pc  = is_mret ? mepc : sepc;
    mis = !rvc && (pc[1:0] != 2'b00);
    e_exc = 1'b1; e_cause = 5'd0;
    if (!is_mret) begin
      if (priv == 2'b00) begin e_cause = 5'd2; tag = "R3"; end
      else if (mis) begin e_cause = 5'd0; tag = "R4"; end
      else if (ms_in[22] && priv != 2'b11) begin e_cause = 5'd2; tag = "R5"; end
      else if (h && virt && hs_in[22]) begin e_cause = 5'd22; tag = "R6"; end
      else e_exc = 1'b0;
    end else begin
      if (priv != 2'b11) begin e_cause = 5'd2; tag = "R9"; end
      else if (mis) begin e_cause = 5'd0; tag = "R4"; end
      else if (!pmp_any && ms_in[12:11] != 2'b11) begin e_cause = 5'd2; tag = "R9"; end
      else e_exc = 1'b0;
    end
    e_ms = ms_in; e_hs = hs_in; e_priv = priv; e_virt = virt;
    if (e_exc) begin
      tag = {tag, "/R11"};
    end else if (!is_mret) begin
      tag = "R7/R8";
      e_ms[1] = ms_in[5];
      e_ms[5] = 1'b1;
      e_ms[8] = 1'b0;
      e_priv  = {1'b0, ms_in[8]};
      if (h && !virt) begin
        e_virt  = hs_in[7];
        e_hs[7] = 1'b0;
      end
    end else begin
      tag = "R10";
      e_ms[3]     = ms_in[7];
      e_ms[7]     = 1'b1;
      e_ms[12:11] = 2'b00;
      e_ms[39]    = 1'b0;
      e_priv      = ms_in[12:11];
      if (h) e_virt = ms_in[39];
    end
  endtask

  task automatic check_one(input bit h, input logic d, input logic x, input logic [4:0] c,
                           input logic [63:0] m, input logic [63:0] hh, input logic [1:0] p,
                           input logic v, input logic [XW-1:0] pc);
    bit e_exc; logic [4:0] e_c; logic [63:0] e_m, e_h; logic [1:0] e_p; logic e_v; string t;
    model(h, e_exc, e_c, e_m, e_h, e_p, e_v, t);
    chk(d === 1'b1, "R2", "done after request", {63'd0, d}, 64'd1);
    chk(x === e_exc && (!e_exc || c === e_c), t, "trap and cause",
        {58'd0, x, c}, {58'd0, e_exc, e_c});
    chk(m === e_m && hh === e_h && p === e_p && v === e_v, t, "state",
        m ^ {hh[31:0], 29'd0, p, v}, e_m ^ {e_h[31:0], 29'd0, e_p, e_v});
    chk(pc === (is_mret ? mepc : sepc), "R11", "return pc",
        {32'd0, pc}, {32'd0, (is_mret ? mepc : sepc)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [63:0] h_ms, h_hs; logic [1:0] h_p; logic h_v; logic [XW-1:0] h_pc;
    rst_n = 1'b0; req = 1'b0; is_mret = 1'b0; priv = 2'b00; virt = 1'b0;
    ms_in = '0; hs_in = '0; sepc = '0; mepc = '0; rvc = 1'b0; pmp_any = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done_a === 1'b0 && exc_a === 1'b0 && done_b === 1'b0 && exc_b === 1'b0,
        "R1", "strobes in reset", {62'd0, done_a, exc_a}, 64'd0);
    chk(ms_a === 64'd0 && hs_a === 64'd0 && priv_a === 2'b00 && virt_a === 1'b0 &&
        pc_a === '0 && cause_a === 5'd0, "R1", "state in reset", ms_a, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_a === 1'b0 && ms_b === 64'd0 && pc_b === '0, "R1", "after release",
        ms_b, 64'd0);

    for (int v = 0; v < 32768; v++) begin
      logic [14:0] b;
      b = v[14:0];
      priv    = b[1:0];
      virt    = b[2];
      is_mret = b[3];
      rvc     = b[4];
      pmp_any = b[9];
      ms_in = {$urandom, $urandom};
      ms_in[5]     = b[13];
      ms_in[7]     = ~b[13];
      ms_in[8]     = b[12];
      ms_in[12:11] = b[11:10];
      ms_in[22]    = b[7];
      ms_in[39]    = b[14];
      hs_in = {$urandom, $urandom};
      hs_in[7]  = b[14] ^ b[0];
      hs_in[22] = b[8];
      sepc = {$urandom} & ~32'h3;
      mepc = {$urandom} & ~32'h3;
      if (is_mret) mepc[1:0] = b[6:5]; else sepc[1:0] = b[6:5];
      if (is_mret) sepc[1:0] = ~b[6:5]; else mepc[1:0] = ~b[6:5];
      req = 1'b1;
      @(negedge clk);
      check_one(1'b1, done_a, exc_a, cause_a, ms_a, hs_a, priv_a, virt_a, pc_a);
      check_one(1'b0, done_b, exc_b, cause_b, ms_b, hs_b, priv_b, virt_b, pc_b);
    end

    // R2 idle: inputs change but outputs hold and strobes stay low
    h_ms = ms_a; h_hs = hs_a; h_p = priv_a; h_v = virt_a; h_pc = pc_a;
    req = 1'b0; ms_in = ~ms_in; hs_in = ~hs_in; priv = ~priv; virt = ~virt;
    sepc = ~sepc; mepc = ~mepc;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done_a === 1'b0 && exc_a === 1'b0 && done_b === 1'b0 && exc_b === 1'b0,
          "R2", "strobes idle", {60'd0, done_a, exc_a, done_b, exc_b}, 64'd0);
      chk(ms_a === h_ms && hs_a === h_hs && priv_a === h_p && virt_a === h_v &&
          pc_a === h_pc, "R2", "hold when idle", ms_a, h_ms);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule